// File: doc/BRIEF.md
# Two-Level Interrupt Status Aggregator

This block gathers interrupt-worthy events from a link controller and folds them into a single level-sensitive interrupt line for a CPU. Events arrive as one-cycle pulses: a message-signalled interrupt pending flag, assert and deassert events for four legacy interrupt lines, power-state and flush events, and a set of general event pulses. Each event sets a sticky bit in one of two first-level cause registers. Software clears a bit by writing one to it.

Each cause register has a mask register beside it, in which a one disables the matching bit. When any unmasked cause bit is set, a sticky core-pending bit in a top-level summary register sets. That summary bit has its own mask. The interrupt line is the summary bit gated by that mask. All registers are reached through a simple register bus with a write strobe, a word address and combinational read data.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, both cause registers and the summary register read 0, mask register 0 reads 0x06FF_FFFF (every valid bit masked except bit 24), mask register 1 reads 0x0000_0FF0, the summary mask reads 0 and `irq_o` is low.
- R2: Cause register 0 maps events as follows: general events [15:0] to bits 15:0, legacy assert line i to bit 16+i, legacy deassert line i to bit 20+i, message pending to bit 24, and spare events [1:0] to bits 26:25. Bits 31:27 always read 0.
- R3: Cause register 1 maps the power-state change to bit 4, flush to bit 5, its two general events to bits 7:6 and legacy assert line i to bit 8+i. Bits 3:0 and 31:12 always read 0.
- R4: A cause bit stays set after its event pulse ends, and a write that puts 0 in that bit position leaves it unchanged.
- R5: Writing 1 to a cause bit clears only that bit in the cycle after the write. If an event for the same bit arrives in the same cycle as the clear, the bit stays set.
- R6: A mask write stores only the register's valid bits. A masked cause bit keeps its raw value readable and does not contribute to the summary.
- R7: Summary bit 16 sets one cycle after any unmasked cause bit is set, and it stays set until written with 1. A clear in a cycle where an unmasked cause is still set has no effect.
- R8: `irq_o` is high exactly while summary bit 16 is set and summary mask bit 16 is 0. Setting that mask bit drops the line without clearing the summary bit.
- R9: Word addresses: 0 cause 0, 1 mask 0, 2 cause 1, 3 mask 1, 4 summary, 5 summary mask (only bit 16 is stored). Addresses 6 and 7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msi_pend_i | input | 1 | Message-signalled interrupt pending pulse |
| intx_assert_i | input | 4 | Legacy line assert pulses, one per line |
| intx_deassert_i | input | 4 | Legacy line deassert pulses, one per line |
| c0_misc_i | input | 16 | General event pulses for cause 0 bits 15:0 |
| c0_spare_i | input | 2 | Event pulses for cause 0 bits 26:25 |
| pwr_chg_i | input | 1 | Power-state change pulse |
| flush_i | input | 1 | Flush event pulse |
| c1_misc_i | input | 2 | Event pulses for cause 1 bits 7:6 |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on the address |
| irq_o | output | 1 | Level-sensitive interrupt to the CPU |

## Verification
Two things collide in a single cycle here. An event pulse can hit the same cause bit that a write-one-to-clear targets. A summary clear can also land while an unmasked cause is still set. The bench provokes both by driving the event input and the write strobe in the same cycle. It judges the result by reading the register back and by comparing every cycle against a behavioural model in which setting is applied after clearing.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int DW = 32;
  localparam int NUM_INTX = 4;

  localparam int C0_AS_LSB  = 16;
  localparam int C0_DE_LSB  = 20;
  localparam int C0_MSI     = 24;
  localparam int C0_SPARE   = 25;
  localparam int C1_PWR     = 4;
  localparam int C1_FLUSH   = 5;
  localparam int C1_MISC    = 6;
  localparam int C1_AS_LSB  = 8;
  localparam int CORE_BIT   = 16;

  localparam logic [DW-1:0] C0_VALID    = 32'h07FF_FFFF;
  localparam logic [DW-1:0] C1_VALID    = 32'h0000_0FF0;
  localparam logic [DW-1:0] C0_MASK_RST = C0_VALID & ~(32'h1 << C0_MSI);
  localparam logic [DW-1:0] C1_MASK_RST = C1_VALID;

  typedef enum logic [2:0] {
    A_CAUSE0 = 3'd0,
    A_MASK0  = 3'd1,
    A_CAUSE1 = 3'd2,
    A_MASK1  = 3'd3,
    A_SUM    = 3'd4,
    A_SMASK  = 3'd5
  } reg_addr_e;

  // New events are applied after the clear, so a same-cycle event wins.
  function automatic logic [DW-1:0] sticky_next(input logic [DW-1:0] cur,
                                                input logic [DW-1:0] set,
                                                input logic [DW-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic [DW-1:0] effective(input logic [DW-1:0] raw,
                                              input logic [DW-1:0] mask,
                                              input logic [DW-1:0] valid);
    return raw & ~mask & valid;
  endfunction
endpackage

// File: rtl/irq_cause_bank.sv
module irq_cause_bank
  import irq_agg_pkg::*;
#(
  parameter int             W        = DW,
  parameter logic [W-1:0]   VALID    = '1,
  parameter logic [W-1:0]   MASK_RST = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_we_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] mask_o,
  output logic         any_o
);
  logic [W-1:0] raw_q, mask_q, clr_vec;

  assign clr_vec = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= MASK_RST;
    end else begin
      raw_q <= sticky_next(raw_q, set_i & VALID, clr_vec);
      if (mask_we_i) mask_q <= wdata_i & VALID;
    end
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign any_o  = |effective(raw_q, mask_q, VALID);
endmodule

// File: rtl/irq_summary.sv
module irq_summary #(
  parameter int W   = 32,
  parameter int BIT = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         any_i,
  input  logic         clr_we_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] wdata_i,
  output logic         pend_o,
  output logic         mask_o,
  output logic         irq_o
);
  logic pend_q, mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~(clr_we_i & wdata_i[BIT])) | any_i;
      if (mask_we_i) mask_q <= wdata_i[BIT];
    end
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;
  assign irq_o  = pend_q & ~mask_q;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                msi_pend_i,
  input  logic [NUM_INTX-1:0] intx_assert_i,
  input  logic [NUM_INTX-1:0] intx_deassert_i,
  input  logic [15:0]         c0_misc_i,
  input  logic [1:0]          c0_spare_i,
  input  logic                pwr_chg_i,
  input  logic                flush_i,
  input  logic [1:0]          c1_misc_i,
  input  logic                reg_we_i,
  input  logic [AW-1:0]       reg_addr_i,
  input  logic [DW-1:0]       reg_wdata_i,
  output logic [DW-1:0]       reg_rdata_o,
  output logic                irq_o
);
  // Named internal events, observed by the bound checker.
  logic [DW-1:0] set0, set1, raw0, raw1, mask0, mask1;
  logic wr_c0, wr_m0, wr_c1, wr_m1, wr_sum, wr_smask;
  logic any0, any1, any_eff, core_pend, core_mask;

  always_comb begin
    set0 = '0;
    set1 = '0;
    set0[15:0]                 = c0_misc_i;
    set0[C0_MSI]               = msi_pend_i;
    set0[C0_SPARE +: 2]        = c0_spare_i;
    set1[C1_PWR]               = pwr_chg_i;
    set1[C1_FLUSH]             = flush_i;
    set1[C1_MISC +: 2]         = c1_misc_i;
    for (int i = 0; i < NUM_INTX; i++) begin
      set0[C0_AS_LSB + i] = intx_assert_i[i];
      set0[C0_DE_LSB + i] = intx_deassert_i[i];
      set1[C1_AS_LSB + i] = intx_assert_i[i];
    end
  end

  assign wr_c0    = reg_we_i && (reg_addr_i == A_CAUSE0);
  assign wr_m0    = reg_we_i && (reg_addr_i == A_MASK0);
  assign wr_c1    = reg_we_i && (reg_addr_i == A_CAUSE1);
  assign wr_m1    = reg_we_i && (reg_addr_i == A_MASK1);
  assign wr_sum   = reg_we_i && (reg_addr_i == A_SUM);
  assign wr_smask = reg_we_i && (reg_addr_i == A_SMASK);

  irq_cause_bank #(.W(DW), .VALID(C0_VALID), .MASK_RST(C0_MASK_RST)) u_bank0 (
    .clk(clk), .rst_n(rst_n), .set_i(set0), .clr_we_i(wr_c0), .mask_we_i(wr_m0),
    .wdata_i(reg_wdata_i), .raw_o(raw0), .mask_o(mask0), .any_o(any0)
  );

  irq_cause_bank #(.W(DW), .VALID(C1_VALID), .MASK_RST(C1_MASK_RST)) u_bank1 (
    .clk(clk), .rst_n(rst_n), .set_i(set1), .clr_we_i(wr_c1), .mask_we_i(wr_m1),
    .wdata_i(reg_wdata_i), .raw_o(raw1), .mask_o(mask1), .any_o(any1)
  );

  assign any_eff = any0 | any1;

  irq_summary #(.W(DW), .BIT(CORE_BIT)) u_sum (
    .clk(clk), .rst_n(rst_n), .any_i(any_eff), .clr_we_i(wr_sum),
    .mask_we_i(wr_smask), .wdata_i(reg_wdata_i), .pend_o(core_pend),
    .mask_o(core_mask), .irq_o(irq_o)
  );

  always_comb begin
    unique case (reg_addr_i)
      A_CAUSE0: reg_rdata_o = raw0;
      A_MASK0:  reg_rdata_o = mask0;
      A_CAUSE1: reg_rdata_o = raw1;
      A_MASK1:  reg_rdata_o = mask1;
      A_SUM:    reg_rdata_o = DW'(core_pend) << CORE_BIT;
      A_SMASK:  reg_rdata_o = DW'(core_mask) << CORE_BIT;
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
  import irq_agg_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          irq,
  input logic          core_pend,
  input logic          core_mask,
  input logic          any_eff,
  input logic          wr_c0,
  input logic          wr_c1,
  input logic [DW-1:0] raw0,
  input logic [DW-1:0] raw1,
  input logic [DW-1:0] set0,
  input logic [DW-1:0] set1
);
  p_valid0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (raw0 & ~C0_VALID) == '0);
  p_valid1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (raw1 & ~C1_VALID) == '0);
  p_sticky0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_c0 |=> ((raw0 & $past(raw0)) == $past(raw0)));
  p_sticky1_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_c1 |=> ((raw1 & $past(raw1)) == $past(raw1)));
  p_event_wins0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (set0 != '0) |=> ((raw0 & $past(set0)) == $past(set0)));
  p_event_wins1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (set1 != '0) |=> ((raw1 & $past(set1)) == $past(set1)));
  p_summary_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    any_eff |=> core_pend);
  p_irq_needs_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> core_pend);
  p_top_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    core_mask |-> !irq);
endmodule

bind irq_aggregator irq_aggregator_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq_o), .core_pend(core_pend),
  .core_mask(core_mask), .any_eff(any_eff), .wr_c0(wr_c0), .wr_c1(wr_c1),
  .raw0(raw0), .raw1(raw1), .set0(set0), .set1(set1)
);

// File: tb/irq_aggregator_bench.sv
`timescale 1ns/100ps
module irq_aggregator_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic msi = 1'b0, pwr = 1'b0, fl = 1'b0, we = 1'b0;
  logic [3:0]  as_ev = '0, de_ev = '0;
  logic [15:0] misc0 = '0;
  logic [1:0]  spare0 = '0, misc1 = '0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_aggregator u_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .msi_pend_i(msi), .intx_assert_i(as_ev),
    .intx_deassert_i(de_ev), .c0_misc_i(misc0), .c0_spare_i(spare0),
    .pwr_chg_i(pwr), .flush_i(fl), .c1_misc_i(misc1), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  // Behavioural reference model.
  logic [31:0] m_c0, m_m0, m_c1, m_m1;
  bit m_top, m_tm;
  localparam logic [31:0] V0 = 32'h07FF_FFFF;
  localparam logic [31:0] V1 = 32'h0000_0FF0;

  always @(posedge clk) begin
    logic [31:0] s0, s1;
    bit hot;
    if (!rst_n) begin
      m_c0 = 0; m_c1 = 0; m_top = 0; m_tm = 0;
      m_m0 = 32'h06FF_FFFF; m_m1 = 32'h0000_0FF0;
    end else begin
      s0 = {5'd0, spare0, msi, de_ev, as_ev, misc0};
      s1 = {20'd0, as_ev, misc1, fl, pwr, 4'd0};
      hot = ((m_c0 & ~m_m0 & V0) != 0) || ((m_c1 & ~m_m1 & V1) != 0);
      if (we && addr == 0) m_c0 = m_c0 & ~wdata;
      if (we && addr == 2) m_c1 = m_c1 & ~wdata;
      if (we && addr == 4 && wdata[16]) m_top = 0;
      m_c0 = m_c0 | s0;
      m_c1 = m_c1 | s1;
      if (hot) m_top = 1;
      if (we && addr == 1) m_m0 = wdata & V0;
      if (we && addr == 3) m_m1 = wdata & V1;
      if (we && addr == 5) m_tm = wdata[16];
    end
  end

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_c0;
      3'd1: return m_m0;
      3'd2: return m_c1;
      3'd3: return m_m1;
      3'd4: return {15'd0, m_top, 16'd0};
      3'd5: return {15'd0, m_tm, 16'd0};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Every-cycle comparison against the model (R8 line, R9 read path).
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R8 irq vs model", {31'd0, irq}, {31'd0, m_top & ~m_tm});
      check("R9 rdata vs model", rdata, m_read(addr));
    end
  end

  task automatic drive_edge();
    @(negedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive_edge();
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    drive_edge();
    addr = a;
    #0.5;
    check(tag, rdata, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    drive_edge();
    we = 1; addr = a; wdata = d;
    drive_edge();
    we = 0; wdata = 0;
  endtask

  task automatic clear_events();
    msi = 0; pwr = 0; fl = 0; as_ev = 0; de_ev = 0;
    misc0 = 0; spare0 = 0; misc1 = 0;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    drive_edge(); rst_n = 1;
    // R1 reset state
    rd(0, 32'h0, "R1 cause0 reset");
    rd(1, 32'h06FF_FFFF, "R1 mask0 reset");
    rd(2, 32'h0, "R1 cause1 reset");
    rd(3, 32'h0000_0FF0, "R1 mask1 reset");
    rd(4, 32'h0, "R1 summary reset");
    rd(5, 32'h0, "R1 summary mask reset");
    check("R1 irq reset", {31'd0, irq}, 32'd0);

    // R2/R3 mapping of legacy assert on line 2
    drive_edge(); as_ev = 4'b0100;
    drive_edge(); clear_events();
    rd(0, 32'h0004_0000, "R2 assert line2 -> bit18");
    rd(2, 32'h0000_0400, "R3 assert line2 -> bit10");
    drive_edge(); de_ev = 4'b0010; misc0 = 16'h0001; spare0 = 2'b10;
    drive_edge(); clear_events();
    rd(0, 32'h0424_0001, "R2 deassert/misc/spare bits");
    check("R6 masked causes keep irq low", {31'd0, irq}, 32'd0);

    // R4 sticky, write of zero leaves bits
    wr(0, 32'h0);
    rd(0, 32'h0424_0001, "R4 zero write keeps bits");
    // R5 W1C of single bit
    wr(0, 32'h0004_0000);
    rd(0, 32'h0420_0001, "R5 clear bit18 only");

    // R6 mask write limited to valid bits; masked msi gives no summary
    wr(1, 32'hFFFF_FFFF);
    rd(1, 32'h07FF_FFFF, "R6 mask0 valid bits only");
    drive_edge(); msi = 1;
    drive_edge(); clear_events();
    idle(2);
    rd(0, 32'h0520_0001, "R6 raw msi readable while masked");
    rd(4, 32'h0, "R6 masked msi no summary");

    // R7/R8 unmask msi -> summary and irq
    wr(1, 32'h06FF_FFFF);
    idle(2);
    rd(4, 32'h0001_0000, "R7 summary set");
    check("R8 irq high", {31'd0, irq}, 32'd1);
    wr(5, 32'h0001_0000);
    check("R8 summary mask drops irq", {31'd0, irq}, 32'd0);
    rd(4, 32'h0001_0000, "R8 summary kept under mask");
    wr(5, 32'h0);
    // R7 clear while cause still live has no effect
    wr(4, 32'h0001_0000);
    rd(4, 32'h0001_0000, "R7 clear ignored while cause live");

    // R5 event and clear of bit24 in the same cycle
    drive_edge(); msi = 1; we = 1; addr = 0; wdata = 32'h0100_0000;
    drive_edge(); clear_events(); we = 0; wdata = 0;
    rd(0, 32'h0520_0001, "R5 event wins over clear");
    wr(0, 32'h0100_0000);
    rd(0, 32'h0420_0001, "R5 bit24 cleared");
    idle(2);
    rd(4, 32'h0001_0000, "R7 summary sticky after cause gone");
    wr(4, 32'h0001_0000);
    rd(4, 32'h0, "R7 summary cleared");
    check("R8 irq low after clear", {31'd0, irq}, 32'd0);

    // R3 cause1 events; unmask power bit -> irq
    drive_edge(); pwr = 1; fl = 1; misc1 = 2'b01;
    drive_edge(); clear_events();
    rd(2, 32'h0000_0470, "R3 pwr/flush/misc bits");
    wr(3, 32'h0000_0FE0);
    idle(2);
    check("R3 unmasked power raises irq", {31'd0, irq}, 32'd1);
    wr(2, 32'hFFFF_FFFF);
    wr(4, 32'h0001_0000);
    idle(1);
    check("R7 all clear irq low", {31'd0, irq}, 32'd0);

    // R9 unused addresses
    wr(6, 32'hFFFF_FFFF);
    wr(7, 32'hFFFF_FFFF);
    rd(6, 32'h0, "R9 addr6 reads zero");
    rd(7, 32'h0, "R9 addr7 reads zero");
    rd(1, 32'h06FF_FFFF, "R9 unused write left mask0");
    rd(3, 32'h0000_0FE0, "R9 unused write left mask1");

    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule